// File: doc/BRIEF.md
# Banked Working-Register File with Stack Pointer

This block holds the 128-byte internal data RAM of a small 8-bit core and resolves every way that core names a byte in it. A register operand (a 3-bit index) is placed in one of four banks of eight bytes chosen by two bank-select bits. A direct byte address reaches any byte, including registers of banks that are not selected. A bit address picks one bit in a 16-byte window starting at byte 0x20. An 8-bit stack pointer serves push and pop.

The block takes one operation per clock. The operation is given by `op_kind` while `op_valid` is high. The RAM has an asynchronous read and a synchronous write, so that a distributed RAM is inferred. Because of this, a single-bit write reads the containing byte, merges the new bit and writes the byte back, all in the same cycle. Every result is registered and appears in the cycle after the operation.

Top module: `banked_regfile`

## Requirements
- R1: A register operation (op_kind 0 read, 1 write) resolves to byte address bank_sel*8 + reg_idx. Banks 0..3 cover bytes 0x00-0x07, 0x08-0x0F, 0x10-0x17 and 0x18-0x1F. The resolved address shows on res_addr one cycle after the operation.
- R2: After reset, sp is 0x07 and range_err and rd_valid are 0. The op_kind codes are: 0 reg read, 1 reg write, 2 direct read, 3 direct write, 4 bit read, 5 bit write, 6 push, 7 pop, 8 load sp. Codes 9-15 have no effect.
- R3: Direct byte operations (2 read, 3 write) on addresses below 0x80 reach any register byte, whatever the value of bank_sel.
- R4: A bit operation (4 read, 5 write) on bit address b in 0x00-0x7F uses byte 0x20 + b/8 and bit position b mod 8. These show on res_addr and res_bit, and the bit read shows on rd_bit.
- R5: A bit write replaces only the addressed bit with wr_bit. The other seven bits of the byte keep their values.
- R6: A push (code 6) increments sp and then writes wr_data at the new sp. A pop (code 7) reads the byte at the current sp onto rd_data and then decrements sp.
- R7: The stack pointer wraps modulo 256. A push at 0xFF moves sp to 0x00 and writes byte 0x00. A pop at 0x00 moves sp to 0xFF.
- R8: An access to a byte address at or above 0x80, a bit address at or above 0x80, or a push or pop whose stack address is at or above 0x80 sets range_err for one cycle. Such an access writes nothing and returns rd_data 0.
- R9: A load-sp operation (code 8) sets sp to the low byte of dir_addr.
- R10: Bytes 0x30-0x7F act as plain RAM. A direct write followed by a direct read returns the written value with range_err low.
- R11: rd_valid is high one cycle after a reg read, direct read, bit read or pop, and low after any other operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_kind | input | 4 | Operation code (see R2) |
| bank_sel | input | 2 | Active register bank |
| reg_idx | input | 3 | Working-register index |
| dir_addr | input | 8 | Direct byte address, bit address, or new sp value |
| wr_data | input | 8 | Byte to write or push |
| wr_bit | input | 1 | Bit value for a bit write |
| res_addr | output | 8 | Resolved byte address of the last operation |
| res_bit | output | 3 | Resolved bit position of the last operation |
| rd_data | output | 8 | Byte read by the last operation (0 when out of range) |
| rd_bit | output | 1 | Bit read by the last bit operation |
| rd_valid | output | 1 | Last operation was a read or pop |
| range_err | output | 1 | Last operation addressed beyond the RAM |
| sp | output | 8 | Current stack pointer |

## Verification
Stack-pointer wrap is the hardest case to reach from the ports. From reset it would take more than 240 pushes, most of them outside the RAM. The bench uses load-sp to place the pointer at 0x7F and then at 0xFF. It then pushes once to hit the out-of-range edge and the wrap to byte 0x00, and reads that byte back as register R0 of bank 0. A bit write that must leave its neighbours intact is also checked: the byte is preloaded with a pattern, two bits in it are set and cleared in turn, and the whole byte is read back after each step.

// File: rtl/rfile_pkg.sv
package rfile_pkg;
  typedef enum logic [3:0] {
    OP_RD_REG = 4'd0,
    OP_WR_REG = 4'd1,
    OP_RD_DIR = 4'd2,
    OP_WR_DIR = 4'd3,
    OP_RD_BIT = 4'd4,
    OP_WR_BIT = 4'd5,
    OP_PUSH   = 4'd6,
    OP_POP    = 4'd7,
    OP_LD_SP  = 4'd8
  } rf_op_e;
endpackage

// File: rtl/rf_addr_resolve.sv
module rf_addr_resolve
  import rfile_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int BANK_W    = 2,
  parameter int IDX_W     = 3,
  parameter int RAM_DEPTH = 128,
  parameter int BIT_BASE  = 32,
  parameter int BIT_BYTES = 16
) (
  input  rf_op_e             op,
  input  logic [BANK_W-1:0]  bank_sel,
  input  logic [IDX_W-1:0]   reg_idx,
  input  logic [ADDR_W-1:0]  dir_addr,
  input  logic [ADDR_W-1:0]  sp_cur,
  input  logic [ADDR_W-1:0]  sp_inc,
  output logic [ADDR_W-1:0]  addr,
  output logic [2:0]         bitpos,
  output logic               is_bit,
  output logic               is_write,
  output logic               is_read,
  output logic               in_range
);
  localparam int PAD_W = ADDR_W - BANK_W - IDX_W;
  localparam logic [ADDR_W:0]   RAM_LIM  = (ADDR_W+1)'(RAM_DEPTH);
  localparam logic [ADDR_W:0]   BIT_LIM  = (ADDR_W+1)'(BIT_BYTES * 8);
  localparam logic [ADDR_W-1:0] BIT_BASE_A = ADDR_W'(BIT_BASE);

  logic bit_ok;

  always_comb begin
    addr     = '0;
    bitpos   = dir_addr[2:0];
    is_bit   = 1'b0;
    is_write = 1'b0;
    is_read  = 1'b0;
    bit_ok   = ({1'b0, dir_addr} < BIT_LIM);
    unique case (op)
      OP_RD_REG, OP_WR_REG: begin
        addr     = {{PAD_W{1'b0}}, bank_sel, reg_idx};
        is_write = (op == OP_WR_REG);
        is_read  = (op == OP_RD_REG);
      end
      OP_RD_DIR, OP_WR_DIR: begin
        addr     = dir_addr;
        is_write = (op == OP_WR_DIR);
        is_read  = (op == OP_RD_DIR);
      end
      OP_RD_BIT, OP_WR_BIT: begin
        addr     = BIT_BASE_A + (dir_addr >> 3);
        is_bit   = 1'b1;
        is_write = (op == OP_WR_BIT);
        is_read  = (op == OP_RD_BIT);
      end
      OP_PUSH: begin
        addr     = sp_inc;
        is_write = 1'b1;
      end
      OP_POP: begin
        addr     = sp_cur;
        is_read  = 1'b1;
      end
      default: begin
        addr = '0;
      end
    endcase
    in_range = ({1'b0, addr} < RAM_LIM) && (!is_bit || bit_ok);
  end
endmodule

// File: rtl/rf_data_ram.sv
module rf_data_ram #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 128,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/rf_stack_ptr.sv
module rf_stack_ptr #(
  parameter int SP_W              = 8,
  parameter logic [SP_W-1:0] SP_RST = 8'h07
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            do_push,
  input  logic            do_pop,
  input  logic            do_load,
  input  logic [SP_W-1:0] load_val,
  output logic [SP_W-1:0] sp_q,
  output logic [SP_W-1:0] sp_inc
);
  assign sp_inc = sp_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst)          sp_q <= SP_RST;
    else if (do_load) sp_q <= load_val;
    else if (do_push) sp_q <= sp_inc;
    else if (do_pop)  sp_q <= sp_q - 1'b1;
  end
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import rfile_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 8,
  parameter int BANK_W    = 2,
  parameter int IDX_W     = 3,
  parameter int RAM_DEPTH = 128,
  parameter int BIT_BASE  = 32,
  parameter int BIT_BYTES = 16,
  parameter logic [ADDR_W-1:0] SP_RST = 8'h07
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  logic [3:0]        op_kind,
  input  logic [BANK_W-1:0] bank_sel,
  input  logic [IDX_W-1:0]  reg_idx,
  input  logic [ADDR_W-1:0] dir_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_bit,
  output logic [ADDR_W-1:0] res_addr,
  output logic [2:0]        res_bit,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_bit,
  output logic              rd_valid,
  output logic              range_err,
  output logic [ADDR_W-1:0] sp
);
  localparam int RAM_AW = $clog2(RAM_DEPTH);

  rf_op_e             op;
  logic [ADDR_W-1:0]  sp_cur, sp_inc, addr;
  logic [2:0]         bitpos;
  logic               is_bit, is_write, is_read, in_range;
  logic [DATA_W-1:0]  rbyte, wbyte, bmask;
  logic               ram_we;

  assign op = rf_op_e'(op_kind);

  rf_stack_ptr #(.SP_W(ADDR_W), .SP_RST(SP_RST)) u_sp (
    .clk      (clk),
    .rst      (rst),
    .do_push  (op_valid && op == OP_PUSH),
    .do_pop   (op_valid && op == OP_POP),
    .do_load  (op_valid && op == OP_LD_SP),
    .load_val (dir_addr),
    .sp_q     (sp_cur),
    .sp_inc   (sp_inc)
  );

  rf_addr_resolve #(
    .ADDR_W(ADDR_W), .BANK_W(BANK_W), .IDX_W(IDX_W),
    .RAM_DEPTH(RAM_DEPTH), .BIT_BASE(BIT_BASE), .BIT_BYTES(BIT_BYTES)
  ) u_res (
    .op       (op),
    .bank_sel (bank_sel),
    .reg_idx  (reg_idx),
    .dir_addr (dir_addr),
    .sp_cur   (sp_cur),
    .sp_inc   (sp_inc),
    .addr     (addr),
    .bitpos   (bitpos),
    .is_bit   (is_bit),
    .is_write (is_write),
    .is_read  (is_read),
    .in_range (in_range)
  );

  // single-cycle merge of one bit into the byte currently stored
  assign bmask  = DATA_W'(1) << bitpos;
  assign wbyte  = is_bit ? ((rbyte & ~bmask) | (wr_bit ? bmask : '0)) : wr_data;
  assign ram_we = op_valid && is_write && in_range;

  rf_data_ram #(.DATA_W(DATA_W), .DEPTH(RAM_DEPTH)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .addr  (addr[RAM_AW-1:0]),
    .wdata (wbyte),
    .rdata (rbyte)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_addr  <= '0;
      res_bit   <= '0;
      rd_data   <= '0;
      rd_bit    <= 1'b0;
      rd_valid  <= 1'b0;
      range_err <= 1'b0;
    end else if (op_valid) begin
      res_addr  <= addr;
      res_bit   <= is_bit ? bitpos : 3'd0;
      rd_data   <= in_range ? rbyte : '0;
      rd_bit    <= in_range && is_bit && rbyte[bitpos];
      rd_valid  <= is_read;
      range_err <= !in_range && (is_read || is_write);
    end else begin
      rd_valid  <= 1'b0;
      range_err <= 1'b0;
    end
  end

  assign sp = sp_cur;
endmodule

// File: rtl/rf_checker.sv
module rf_checker
  import rfile_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int BANK_W = 2,
  parameter int IDX_W  = 3,
  parameter logic [ADDR_W-1:0] SP_RST = 8'h07
) (
  input logic              clk,
  input logic              rst,
  input logic              op_valid,
  input logic [3:0]        op_kind,
  input logic [BANK_W-1:0] bank_sel,
  input logic [IDX_W-1:0]  reg_idx,
  input logic [ADDR_W-1:0] dir_addr,
  input logic [ADDR_W-1:0] res_addr,
  input logic              range_err,
  input logic              rd_valid,
  input logic [ADDR_W-1:0] sp
);
  localparam int PAD_W = ADDR_W - BANK_W - IDX_W;

  AST_SP_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> sp == SP_RST); // R2

  AST_REG_MAP: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_kind == OP_RD_REG) |=>
      res_addr == {{PAD_W{1'b0}}, $past(bank_sel), $past(reg_idx)}); // R1

  AST_PUSH_INC: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_kind == OP_PUSH) |=> sp == $past(sp) + 1'b1); // R6

  AST_POP_DEC: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_kind == OP_POP) |=> sp == $past(sp) - 1'b1); // R6

  AST_LOAD_SP: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_kind == OP_LD_SP) |=> sp == $past(dir_addr)); // R9

  AST_OOR_DIRECT: assert property (@(posedge clk) disable iff (rst)
    (op_valid && (op_kind == OP_RD_DIR || op_kind == OP_WR_DIR) && dir_addr[ADDR_W-1])
      |=> range_err); // R8

  AST_BIT_WINDOW: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_kind == OP_RD_BIT && !dir_addr[ADDR_W-1])
      |=> (res_addr[ADDR_W-1:4] == 'd2 && !range_err)); // R4

  AST_RDVALID_IDLE: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> !rd_valid && !range_err); // R11
endmodule

bind banked_regfile rf_checker #(
  .ADDR_W(ADDR_W), .BANK_W(BANK_W), .IDX_W(IDX_W), .SP_RST(SP_RST)
) u_chk (
  .clk(clk), .rst(rst), .op_valid(op_valid), .op_kind(op_kind),
  .bank_sel(bank_sel), .reg_idx(reg_idx), .dir_addr(dir_addr),
  .res_addr(res_addr), .range_err(range_err), .rd_valid(rd_valid), .sp(sp)
);

// File: tb/tb_banked_regfile.sv
`timescale 1ns/1ps
module tb_banked_regfile;
  logic       clk = 1'b0;
  logic       rst;
  logic       op_valid;
  logic [3:0] op_kind;
  logic [1:0] bank_sel;
  logic [2:0] reg_idx;
  logic [7:0] dir_addr, wr_data;
  logic       wr_bit;
  logic [7:0] res_addr, rd_data, sp;
  logic [2:0] res_bit;
  logic       rd_bit, rd_valid, range_err;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  banked_regfile dut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_kind(op_kind),
    .bank_sel(bank_sel), .reg_idx(reg_idx), .dir_addr(dir_addr),
    .wr_data(wr_data), .wr_bit(wr_bit), .res_addr(res_addr), .res_bit(res_bit),
    .rd_data(rd_data), .rd_bit(rd_bit), .rd_valid(rd_valid),
    .range_err(range_err), .sp(sp)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // apply one operation, return after the result register has updated
  task automatic op(input int k, input int b, input int i, input int a,
                    input int d, input bit wb);
    @(negedge clk);
    op_valid = 1'b1; op_kind = 4'(k); bank_sel = 2'(b); reg_idx = 3'(i);
    dir_addr = 8'(a); wr_data = 8'(d); wr_bit = wb;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1; op_valid = 1'b0; op_kind = '0; bank_sel = '0; reg_idx = '0;
    dir_addr = '0; wr_data = '0; wr_bit = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R2", "sp", sp, 8'h07);
    chk("R2", "range_err", range_err, 0);
    chk("R2", "rd_valid", rd_valid, 0);
  endtask

  task automatic t_banks();
    for (int b = 0; b < 4; b++) op(1, b, 5, 0, 8'h50 + b, 0);
    for (int b = 0; b < 4; b++) begin
      op(0, b, 5, 0, 0, 0);
      chk("R1", "reg addr", res_addr, b * 8 + 5);
      chk("R1", "reg data", rd_data, 8'h50 + b);
      chk("R11", "rd_valid", rd_valid, 1);
    end
    // R3: direct reach into banks while bank_sel points elsewhere
    for (int b = 0; b < 4; b++) begin
      op(2, 3 - b, 0, b * 8 + 5, 0, 0);
      chk("R3", "direct into bank", rd_data, 8'h50 + b);
    end
    op(3, 0, 0, 8'h1A, 8'hC3, 0);
    op(0, 3, 2, 0, 0, 0);
    chk("R3", "direct write seen as bank3 R2", rd_data, 8'hC3);
    op(9, 0, 0, 8'h1A, 8'h00, 0);
    chk("R2", "unused code rd_valid", rd_valid, 0);
    op(2, 0, 0, 8'h1A, 0, 0);
    chk("R2", "unused code no write", rd_data, 8'hC3);
  endtask

  task automatic t_bits();
    op(3, 0, 0, 8'h25, 8'hA4, 0);
    op(5, 0, 0, 8'h2B, 0, 1);       // byte 0x25 bit 3 set
    chk("R4", "bit byte addr", res_addr, 8'h25);
    chk("R4", "bit pos", res_bit, 3);
    op(2, 0, 0, 8'h25, 0, 0);
    chk("R5", "set bit3", rd_data, 8'hAC);
    op(5, 0, 0, 8'h2A, 0, 0);       // clear bit 2
    op(2, 0, 0, 8'h25, 0, 0);
    chk("R5", "clear bit2", rd_data, 8'hA8);
    op(4, 0, 0, 8'h2F, 0, 0);       // bit 7 of 0x25
    chk("R4", "read bit7", rd_bit, 1);
    op(4, 0, 0, 8'h28, 0, 0);
    chk("R4", "read bit0", rd_bit, 0);
    op(3, 0, 0, 8'h2F, 8'h00, 0);
    op(5, 0, 0, 8'h7F, 0, 1);
    chk("R4", "top bit addr", res_addr, 8'h2F);
    op(2, 0, 0, 8'h2F, 0, 0);
    chk("R5", "top bit write", rd_data, 8'h80);
  endtask

  task automatic t_stack();
    op(6, 0, 0, 0, 8'hAA, 0);
    chk("R6", "push sp", sp, 8'h08);
    chk("R6", "push addr", res_addr, 8'h08);
    op(6, 0, 0, 0, 8'hBB, 0);
    op(2, 0, 0, 8'h08, 0, 0);
    chk("R6", "pushed byte", rd_data, 8'hAA);
    op(7, 0, 0, 0, 0, 0);
    chk("R6", "pop data", rd_data, 8'hBB);
    chk("R6", "pop addr", res_addr, 8'h09);
    chk("R6", "pop sp", sp, 8'h08);
    op(7, 0, 0, 0, 0, 0);
    chk("R6", "pop2 data", rd_data, 8'hAA);
    chk("R6", "pop2 sp", sp, 8'h07);
    op(8, 0, 0, 8'h30, 0, 0);
    chk("R9", "load sp", sp, 8'h30);
  endtask

  task automatic t_range();
    op(3, 0, 0, 8'h00, 8'h5A, 0);
    op(2, 0, 0, 8'h85, 0, 0);
    chk("R8", "oor read flag", range_err, 1);
    chk("R8", "oor read data", rd_data, 0);
    op(3, 0, 0, 8'h80, 8'h77, 0);
    chk("R8", "oor write flag", range_err, 1);
    op(2, 0, 0, 8'h00, 0, 0);
    chk("R8", "no alias write", rd_data, 8'h5A);
    chk("R8", "in-range flag low", range_err, 0);
    op(4, 0, 0, 8'h90, 0, 0);
    chk("R8", "oor bit flag", range_err, 1);
  endtask

  task automatic t_wrap();
    op(8, 0, 0, 8'h7F, 0, 0);
    op(6, 0, 0, 0, 8'h11, 0);
    chk("R8", "push past ram flag", range_err, 1);
    chk("R7", "sp 0x80", sp, 8'h80);
    op(8, 0, 0, 8'hFF, 0, 0);
    op(6, 0, 0, 0, 8'h22, 0);
    chk("R7", "sp wrapped", sp, 8'h00);
    chk("R7", "wrap flag low", range_err, 0);
    op(0, 0, 0, 0, 0, 0);
    chk("R7", "byte0 via bank0 R0", rd_data, 8'h22);
    op(7, 0, 0, 0, 0, 0);
    chk("R7", "pop wraps", sp, 8'hFF);
    chk("R7", "pop data", rd_data, 8'h22);
  endtask

  task automatic t_plain();
    op(3, 0, 0, 8'h30, 8'h3C, 0);
    op(3, 0, 0, 8'h7F, 8'hE1, 0);
    op(2, 0, 0, 8'h30, 0, 0);
    chk("R10", "byte 0x30", rd_data, 8'h3C);
    op(2, 0, 0, 8'h7F, 0, 0);
    chk("R10", "byte 0x7F", rd_data, 8'hE1);
    chk("R10", "flag low", range_err, 0);
    @(negedge clk);
    chk("R11", "idle rd_valid", rd_valid, 0);
  endtask

  initial begin
    t_reset();
    t_banks();
    t_bits();
    t_stack();
    t_range();
    t_wrap();
    t_plain();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #500000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule